// File: doc/BRIEF.md
# Interleaved I/Q Polyphase CIC Decimator

This block is a multiplierless decimator for the in-phase and quadrature paths of a digital down-converter. Both paths enter on one sample stream, each sample tagged with a channel bit, in any order. One filter datapath serves both paths. Every delay element keeps a separate entry for each channel, and the tag of the accepted sample selects the entry. The response is that of a three-stage cascaded integrator-comb filter that decimates by `DEC` (default 5). With these defaults it is a 13-tap integer FIR. Its taps are the coefficients of the cube of a length-`DEC` boxcar.

The filter is not built as integrators running at the input rate. It is split into `DEC` polyphase branches. Each branch holds at most `STAGES` taps, and every tap is a fixed shift-and-add. The branches are evaluated only on the sample that completes a decimation group, and their partial sums are added. Arithmetic is full-precision two's complement. The result is then pruned to `OUT_W` bits by dropping least-significant bits.

Top module: `cic_iq_decim`

## Requirements
- R1: A result carries on `out_chan` the tag of the input sample that produced it (0 = I, 1 = Q). The result for one channel never depends on samples of the other channel.
- R2: For each channel, a result is produced on exactly every `DEC`-th accepted sample of that channel, counted from reset. No result is produced on any other cycle.
- R3: A result equals the sum over k = 0..TAPS-1 of h[k]·x[n-k]. Here x[n] is the sample that completes the group, and h are the coefficients of (1+z⁻¹+…+z⁻⁽ᴰᴱᶜ⁻¹⁾)^STAGES. For the defaults these are 1,3,6,10,15,18,19,18,15,10,6,3,1.
- R4: With a constant input x on a channel, the settled result is DEC^STAGES·x, which is 125·x by default.
- R5: An I-only stimulus leaves every Q result at zero.
- R6: The first `STAGES-1` groups of each channel after reset produce no result. The first result comes on the 15th sample of a channel by default.
- R7: `out_data` is the top `OUT_W` bits of the full-precision sum, of width IN_W+STAGES·clog2(DEC). This equals the full result arithmetically shifted right, rounding toward minus infinity.
- R8: A synchronous active-high `rst` clears all delay entries and the phase and fill counters of both channels, and holds `out_valid` low.
- R9: `out_valid` is high only in the cycle after an accepted sample (`in_valid` high). Idle cycles change no state.
- R10: Result latency is one clock: the result appears registered in the cycle after the completing sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present this cycle |
| in_chan | input | 1 | Channel tag of the input sample, 0 = I, 1 = Q |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Result present this cycle |
| out_chan | output | 1 | Channel tag of the result |
| out_data | output | OUT_W | Signed, pruned result |

## Verification
The bench drives a lone impulse through the I path while Q stays silent. A wrong tap, or a wrong assignment of taps to branches, shows as a misplaced value in the 13-term response. A leak of state between channels shows as nonzero Q results. Constant inputs at both full-scale extremes check the gain of 125 and the rounding of negative results on pruning. A pruner that rounds toward zero, or picks the wrong slice, is off by one or off by a power of two. Long runs of randomly sized per-channel bursts with idle gaps check per-channel phase keeping against a separate integrator-comb model for each channel. A shared phase counter, or one that advances on idle cycles, puts results at the wrong samples. A mid-stream reset checks that the fill suppression restarts, so that stale history cannot leak into the first results.

// File: rtl/cic_iq_pkg.sv
package cic_iq_pkg;

    typedef enum logic {
        CH_I = 1'b0,
        CH_Q = 1'b1
    } chan_e;

    localparam int COEF_SPAN = 64;

    // Coefficient idx of (sum_{i<dec} z^-i)^stages, by repeated convolution.
    function automatic int cic_coef(input int dec, input int stages, input int idx);
        int cur [COEF_SPAN];
        int nxt [COEF_SPAN];
        for (int i = 0; i < COEF_SPAN; i++) cur[i] = 0;
        cur[0] = 1;
        for (int s = 0; s < stages; s++) begin
            for (int i = 0; i < COEF_SPAN; i++) nxt[i] = 0;
            for (int i = 0; i < COEF_SPAN; i++) begin
                for (int j = 0; j < dec; j++) begin
                    if (i + j < COEF_SPAN) nxt[i + j] = nxt[i + j] + cur[i];
                end
            end
            cur = nxt;
        end
        if (idx < 0 || idx >= COEF_SPAN) return 0;
        return cur[idx];
    endfunction

    function automatic int tap_count(input int dec, input int stages);
        return stages * (dec - 1) + 1;
    endfunction

    function automatic int full_width(input int in_w, input int dec, input int stages);
        return in_w + stages * $clog2(dec);
    endfunction

endpackage

// File: rtl/cic_iq_phase.sv
module cic_iq_phase
    import cic_iq_pkg::*;
#(
    parameter int DEC    = 5,
    parameter int STAGES = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  chan_e in_chan,
    output logic  emit
);
    localparam int PH_W = (DEC > 1) ? $clog2(DEC) : 1;
    localparam int FILL = STAGES - 1;
    localparam int FW   = $clog2(STAGES) + 1;

    logic [PH_W-1:0] phase_q [2];
    logic [FW-1:0]   fill_q  [2];
    logic            sel;
    logic            grp_end;

    always_comb begin
        sel     = in_chan;
        grp_end = in_valid && (phase_q[sel] == PH_W'(DEC - 1));
        emit    = grp_end && (fill_q[sel] == FW'(FILL));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                phase_q[c] <= '0;
                fill_q[c]  <= '0;
            end
        end else if (in_valid) begin
            if (grp_end) begin
                phase_q[sel] <= '0;
                if (fill_q[sel] != FW'(FILL)) fill_q[sel] <= fill_q[sel] + 1'b1;
            end else begin
                phase_q[sel] <= phase_q[sel] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cic_iq_history.sv
module cic_iq_history
    import cic_iq_pkg::*;
#(
    parameter int IN_W = 12,
    parameter int TAPS = 13
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  chan_e                  in_chan,
    input  logic signed [IN_W-1:0] in_data,
    output logic signed [IN_W-1:0] win [TAPS]
);
    localparam int DEPTH = TAPS - 1;

    logic signed [IN_W-1:0] hist_q [2][DEPTH];
    logic                   sel;

    assign sel = in_chan;

    always_comb begin
        win[0] = in_data;
        for (int k = 1; k < TAPS; k++) win[k] = hist_q[sel][k-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++)
                for (int k = 0; k < DEPTH; k++) hist_q[c][k] <= '0;
        end else if (in_valid) begin
            hist_q[sel][0] <= in_data;
            for (int k = 1; k < DEPTH; k++) hist_q[sel][k] <= hist_q[sel][k-1];
        end
    end

endmodule

// File: rtl/cic_iq_branch.sv
module cic_iq_branch
    import cic_iq_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int ACC_W  = 21,
    parameter int DEC    = 5,
    parameter int STAGES = 3,
    parameter int PHASE  = 0
) (
    input  logic signed [IN_W-1:0]  win [tap_count(DEC, STAGES)],
    output logic signed [ACC_W-1:0] psum
);
    localparam int TAPS = tap_count(DEC, STAGES);

    // Constant multiply realised as a sum of shifted copies of the sample.
    function automatic logic signed [ACC_W-1:0] shadd(
        input logic signed [IN_W-1:0] x,
        input int                     c
    );
        logic signed [ACC_W-1:0] r;
        logic signed [ACC_W-1:0] xe;
        r  = '0;
        xe = ACC_W'(x);
        for (int b = 0; b < 31; b++) begin
            if (c[b]) r = r + (xe <<< b);
        end
        return r;
    endfunction

    logic signed [ACC_W-1:0] term [STAGES];

    for (genvar j = 0; j < STAGES; j++) begin : g_tap
        localparam int K = PHASE + DEC * j;
        if (K < TAPS) begin : g_live
            localparam int CF = cic_coef(DEC, STAGES, K);
            assign term[j] = shadd(win[K], CF);
        end else begin : g_pad
            assign term[j] = '0;
        end
    end

    always_comb begin
        psum = '0;
        for (int j = 0; j < STAGES; j++) psum = psum + term[j];
    end

endmodule

// File: rtl/cic_iq_decim.sv
module cic_iq_decim
    import cic_iq_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int DEC    = 5,
    parameter int STAGES = 3,
    parameter int OUT_W  = IN_W + STAGES * $clog2(DEC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_chan,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic                    out_chan,
    output logic signed [OUT_W-1:0] out_data
);
    localparam int TAPS   = tap_count(DEC, STAGES);
    localparam int FULL_W = full_width(IN_W, DEC, STAGES);

    chan_e                    chan;
    logic                     emit;
    logic signed [IN_W-1:0]   win  [TAPS];
    logic signed [FULL_W-1:0] part [DEC];
    logic signed [FULL_W-1:0] total;

    assign chan = chan_e'(in_chan);

    cic_iq_phase #(
        .DEC    (DEC),
        .STAGES (STAGES)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_chan  (chan),
        .emit     (emit)
    );

    cic_iq_history #(
        .IN_W (IN_W),
        .TAPS (TAPS)
    ) u_hist (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_chan  (chan),
        .in_data  (in_data),
        .win      (win)
    );

    for (genvar p = 0; p < DEC; p++) begin : g_branch
        cic_iq_branch #(
            .IN_W   (IN_W),
            .ACC_W  (FULL_W),
            .DEC    (DEC),
            .STAGES (STAGES),
            .PHASE  (p)
        ) u_branch (
            .win  (win),
            .psum (part[p])
        );
    end

    always_comb begin
        total = '0;
        for (int p = 0; p < DEC; p++) total = total + part[p];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_chan  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_chan <= in_chan;
                out_data <= total[FULL_W-1 -: OUT_W];
            end
        end
    end

endmodule

// File: rtl/cic_iq_decim_chk.sv
module cic_iq_decim_chk #(
    parameter int DEC    = 5,
    parameter int STAGES = 3
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_chan,
    input logic out_valid,
    input logic out_chan
);
    int mod_q [2];
    int grp_q [2];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                mod_q[c] <= 0;
                grp_q[c] <= 0;
            end
        end else if (in_valid) begin
            if (mod_q[in_chan] == DEC - 1) begin
                mod_q[in_chan] <= 0;
                if (grp_q[in_chan] < STAGES) grp_q[in_chan] <= grp_q[in_chan] + 1;
            end else begin
                mod_q[in_chan] <= mod_q[in_chan] + 1;
            end
        end
    end

    p_tag_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_chan == $past(in_chan)));

    p_only_after_input_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    p_mid_group_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mod_q[in_chan] != DEC - 1) |=> !out_valid);

    p_group_end_emits_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mod_q[in_chan] == DEC - 1 && grp_q[in_chan] >= STAGES - 1) |=> out_valid);

    p_fill_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && grp_q[in_chan] < STAGES - 1) |=> !out_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

bind cic_iq_decim cic_iq_decim_chk #(
    .DEC    (DEC),
    .STAGES (STAGES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_chan   (in_chan),
    .out_valid (out_valid),
    .out_chan  (out_chan)
);

// File: tb/cic_iq_decim_bench.sv
`timescale 1ns/1ps
module cic_iq_decim_bench;
    localparam int IN_W   = 12;
    localparam int DEC    = 5;
    localparam int STAGES = 3;
    localparam int FULL_W = 21;
    localparam int PR_W   = 14;
    localparam int SHIFT  = FULL_W - PR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_chan = 1'b0;
    logic signed [IN_W-1:0] in_data = '0;
    logic out_valid, out_chan, pr_valid, pr_chan;
    logic signed [FULL_W-1:0] out_data;
    logic signed [PR_W-1:0]   pr_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cic_iq_decim #(.IN_W(IN_W), .DEC(DEC), .STAGES(STAGES)) u_cic_iq_decim (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
        .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data));

    cic_iq_decim #(.IN_W(IN_W), .DEC(DEC), .STAGES(STAGES), .OUT_W(PR_W)) u_prune (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
        .out_valid(pr_valid), .out_chan(pr_chan), .out_data(pr_data));

    // Reference: separate integrator-comb filters per channel.
    longint integ [2][STAGES];
    longint dly   [2][STAGES];
    int     ph    [2];
    int     grp   [2];
    longint last_y [2];

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            for (int s = 0; s < STAGES; s++) begin
                integ[c][s] = 0;
                dly[c][s] = 0;
            end
            ph[c] = 0;
            grp[c] = 0;
            last_y[c] = 0;
        end
    endtask

    task automatic model_step(input int c, input longint x, output bit emit, output longint y);
        longint v, t;
        integ[c][0] += x;
        for (int s = 1; s < STAGES; s++) integ[c][s] += integ[c][s-1];
        emit = 0;
        y = 0;
        ph[c]++;
        if (ph[c] == DEC) begin
            ph[c] = 0;
            v = integ[c][STAGES-1];
            for (int s = 0; s < STAGES; s++) begin
                t = v - dly[c][s];
                dly[c][s] = v;
                v = t;
            end
            grp[c]++;
            emit = (grp[c] >= STAGES);
            y = v;
        end
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check registered outputs just after the posedge.
    task automatic cycle(input bit v, input bit c, input int d, input string req);
        bit emit;
        longint y;
        @(negedge clk);
        in_valid = v;
        in_chan  = c;
        in_data  = IN_W'(d);
        emit = 0;
        y = 0;
        if (v) model_step(int'(c), longint'(d), emit, y);
        @(posedge clk);
        #1;
        check(out_valid == emit, "R2", longint'(out_valid), longint'(emit));
        check(pr_valid == emit, "R9", longint'(pr_valid), longint'(emit));
        if (emit && out_valid) begin
            last_y[c] = y;
            check(out_chan == c, "R1", longint'(out_chan), longint'(c));
            check(longint'(out_data) == y, req, longint'(out_data), y);
            check(longint'(pr_data) == (y >>> SHIFT), "R7", longint'(pr_data), y >>> SHIFT);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        check(out_valid == 1'b0 && pr_valid == 1'b0, "R8", longint'(out_valid), 0);
        rst = 1'b0;
    endtask

    initial begin
        model_reset();
        do_reset();

        // R3 and R5: impulse on I only, strict alternation, Q silent.
        for (int n = 0; n < 40; n++) begin
            cycle(1'b1, 1'b0, (n == 14) ? 1000 : 0, "R3");
            cycle(1'b1, 1'b1, 0, "R5");
        end
        check(last_y[1] == 0, "R5", last_y[1], 0);

        // R4: constant inputs settle to 125 times the input, both extremes.
        do_reset();
        for (int n = 0; n < 40; n++) begin
            cycle(1'b1, 1'b0, 2047, "R4");
            cycle(1'b1, 1'b1, -2048, "R4");
        end
        check(last_y[0] == 125 * 2047, "R4", last_y[0], 125 * 2047);
        check(last_y[1] == -125 * 2048, "R4", last_y[1], -125 * 2048);
        check(longint'(out_data) == -125 * 2048, "R4", longint'(out_data), -125 * 2048);

        // R6: mid-stream reset restarts the fill suppression (checked per cycle).
        do_reset();
        for (int n = 0; n < 20; n++) cycle(1'b1, 1'b1, 700, "R6");

        // R9, R10, R1: random bursts per channel with idle gaps.
        do_reset();
        for (int b = 0; b < 400; b++) begin
            bit ch;
            int len;
            ch  = 1'($urandom_range(0, 1));
            len = int'($urandom_range(1, 7));
            for (int k = 0; k < len; k++) begin
                cycle(1'b1, ch, int'($urandom_range(0, 4095)) - 2048, "R3");
                if ($urandom_range(0, 3) == 0) cycle(1'b0, ch, int'($urandom_range(0, 4095)) - 2048, "R9");
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule